// File: doc/BRIEF.md
# Credit-Gated Transmit Request Arbiter

This block decides, on the transmit side of a packet transaction layer, when the application may send a packet. For each of three traffic classes (posted, non-posted, completion) it holds a header credit counter and a data credit counter, and it drives all six counts onto output ports on every cycle. The application may read these counts before it asks to send, or it may ignore them. The block makes its own check either way.

To send, the application raises a request with the traffic class and the payload length in dwords. If the selected class has at least one header credit and enough data credits, the block acknowledges in the same cycle and takes the credits at that clock edge. If not, the request is postponed, nothing is taken, and the block checks again on every cycle while the request stays up. After an acknowledge, the block forwards one descriptor beat and then each payload word to the downstream layer. The application must deliver the payload words on back-to-back cycles. A missing word is recorded as a protocol error, and the packet's last word is marked as bad. Credit returns from the far end arrive on a separate port. They are added back to the counters, which saturate at a configured limit.

Top module: `txcg_arbiter`

## Requirements
- R1: After reset, every class reports HC_INIT header credits and DC_INIT data credits, with no acknowledge, no downstream beat and no protocol error. avail_hdr and avail_dat carry class k in slice k, where class code 0 = posted, 1 = non-posted, 2 = completion and 3 = reserved.
- R2: req_ack is high in the same cycle as req_valid only when all of these hold: the block is idle, req_cls is 0, 1 or 2, that class has at least one header credit, and it has at least ceil(req_len/4) data credits. Reserved class 3 is never acknowledged.
- R3: A postponed request takes no credits and produces no downstream beat. If it is held, it is checked again on every cycle and is granted in the first cycle in which its class has enough credits.
- R4: On the acknowledge edge, the selected class loses one header credit and ceil(req_len/4) data credits. The new counts are visible from the next cycle.
- R5: When ret_valid is high, ret_hdr and ret_dat are added to class ret_cls, and each counter is clipped to HC_LIM or DC_LIM. A return and a consume on the same class in the same cycle combine into one net update.
- R6: In the cycle after an acknowledge, a descriptor beat appears with dn_valid=1 and dn_sop=1. dn_data holds the class in bits [LEN_W+1:LEN_W] and the length in bits [LEN_W-1:0], with zeros above. dn_last=1 exactly when the length is 0.
- R7: Each payload word accepted after an acknowledge is forwarded on dn_data one cycle later with dn_valid=1 and dn_sop=0. dn_last=1 marks the req_len-th word.
- R8: A cycle inside the payload phase without pl_valid produces no downstream beat. It sets proto_err from the next cycle until reset, and dn_err=1 on that packet's last word. A packet with no gap has dn_err=0.
- R9: Only one packet is in flight at a time. No request is acknowledged during the payload phase, and pl_valid is ignored while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| avail_hdr | output | 3*HC_W | Header credits per class, class k in slice k |
| avail_dat | output | 3*DC_W | Data credits per class, class k in slice k |
| req_valid | input | 1 | Transmit request |
| req_cls | input | 2 | Traffic class of the request |
| req_len | input | LEN_W | Payload length in dwords (0 = header only) |
| req_ack | output | 1 | Request granted this cycle |
| pl_valid | input | 1 | Payload word present |
| pl_data | input | WORD_W | Payload word |
| ret_valid | input | 1 | Credit return present |
| ret_cls | input | 2 | Class receiving the returned credits |
| ret_hdr | input | HC_W | Returned header credits |
| ret_dat | input | DC_W | Returned data credits |
| dn_valid | output | 1 | Downstream beat valid |
| dn_sop | output | 1 | Beat is the packet descriptor |
| dn_last | output | 1 | Beat is the last of the packet |
| dn_err | output | 1 | Packet had a payload gap (on last beat) |
| dn_data | output | WORD_W | Descriptor or payload word |
| proto_err | output | 1 | Sticky payload-gap flag |

## Verification
The assertions check on every cycle that the counters never pass their limits, that a consume never happens without enough credits, and that an acknowledge never comes for a reserved class or while a payload is in flight. They also check that a postponed request with no return leaves the counters unchanged, and that a payload gap sets the sticky error flag, which then stays set. Only the bench's scenarios can show that the arithmetic is right: the round-up of data credits over every length, saturation with and without a consume in the same cycle, a held request being granted once credits come back, and the exact contents and ordering of the descriptor and payload beats, including where dn_err lands.

// File: rtl/txcg_pkg.sv
package txcg_pkg;
  localparam int NUM_CLS = 3;
  typedef enum logic [1:0] {
    CLS_POST  = 2'd0,
    CLS_NPOST = 2'd1,
    CLS_CPL   = 2'd2,
    CLS_RSVD  = 2'd3
  } tx_cls_e;
endpackage

// File: rtl/txcg_credit_pool.sv
module txcg_credit_pool #(
  parameter int HC_W    = 8,
  parameter int DC_W    = 10,
  parameter int HC_INIT = 4,
  parameter int DC_INIT = 16,
  parameter int HC_LIM  = 8,
  parameter int DC_LIM  = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [DC_W-1:0] need_dat,
  input  logic            give,
  input  logic [HC_W-1:0] give_hdr,
  input  logic [DC_W-1:0] give_dat,
  output logic [HC_W-1:0] hdr_cnt,
  output logic [DC_W-1:0] dat_cnt,
  output logic            fits
);
  localparam int HS_W = HC_W + 1;
  localparam int DS_W = DC_W + 1;

  logic [HC_W-1:0] hdr_q, hdr_n;
  logic [DC_W-1:0] dat_q, dat_n;
  logic [HS_W-1:0] h_sum;
  logic [DS_W-1:0] d_sum;
  logic            upd;

  assign fits = (hdr_q != '0) && (dat_q >= need_dat);
  assign upd  = take | give;

  always_comb begin
    h_sum = {1'b0, hdr_q} + (give ? {1'b0, give_hdr} : '0) - (take ? HS_W'(1) : '0);
    d_sum = {1'b0, dat_q} + (give ? {1'b0, give_dat} : '0) - (take ? {1'b0, need_dat} : '0);
    hdr_n = (h_sum > HS_W'(HC_LIM)) ? HC_W'(HC_LIM) : h_sum[HC_W-1:0];
    dat_n = (d_sum > DS_W'(DC_LIM)) ? DC_W'(DC_LIM) : d_sum[DC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q <= HC_W'(HC_INIT);
      dat_q <= DC_W'(DC_INIT);
    end else if (upd) begin
      hdr_q <= hdr_n;
      dat_q <= dat_n;
    end
  end

  assign hdr_cnt = hdr_q;
  assign dat_cnt = dat_q;

  // R5
  hdr_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_q <= HC_W'(HC_LIM));
  // R5
  dat_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_q <= DC_W'(DC_LIM));
  // R4
  take_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> fits);
  // R4
  take_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !give |=> hdr_q == $past(hdr_q) - HC_W'(1));
endmodule

// File: rtl/txcg_tx_seq.sv
module txcg_tx_seq #(
  parameter int LEN_W  = 6,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack,
  input  logic [1:0]        ack_cls,
  input  logic [LEN_W-1:0]  ack_len,
  input  logic              pl_valid,
  input  logic [WORD_W-1:0] pl_data,
  output logic              idle,
  output logic              dn_valid,
  output logic              dn_sop,
  output logic              dn_last,
  output logic              dn_err,
  output logic [WORD_W-1:0] dn_data,
  output logic              proto_err
);
  logic              busy_q, busy_n;
  logic [LEN_W-1:0]  rem_q, rem_n;
  logic              perr_pkt_q, perr_pkt_n;
  logic              perr_q, perr_n;
  logic              vld_q, vld_n, sop_q, sop_n, last_q, last_n, err_q, err_n;
  logic [WORD_W-1:0] data_q, data_n;
  logic              at_last;

  assign at_last = (rem_q == LEN_W'(1));

  always_comb begin
    busy_n     = busy_q;
    rem_n      = rem_q;
    perr_pkt_n = perr_pkt_q;
    perr_n     = perr_q;
    vld_n      = 1'b0;
    sop_n      = 1'b0;
    last_n     = 1'b0;
    err_n      = 1'b0;
    data_n     = data_q;
    if (!busy_q) begin
      if (ack) begin
        vld_n      = 1'b1;
        sop_n      = 1'b1;
        data_n     = WORD_W'({ack_cls, ack_len});
        last_n     = (ack_len == '0);
        busy_n     = (ack_len != '0);
        rem_n      = ack_len;
        perr_pkt_n = 1'b0;
      end
    end else if (pl_valid) begin
      vld_n  = 1'b1;
      data_n = pl_data;
      last_n = at_last;
      err_n  = at_last & perr_pkt_q;
      rem_n  = rem_q - LEN_W'(1);
      if (at_last) begin
        busy_n     = 1'b0;
        perr_pkt_n = 1'b0;
      end
    end else begin
      perr_n     = 1'b1;
      perr_pkt_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      rem_q      <= '0;
      perr_pkt_q <= 1'b0;
      perr_q     <= 1'b0;
      vld_q      <= 1'b0;
      sop_q      <= 1'b0;
      last_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      busy_q     <= busy_n;
      rem_q      <= rem_n;
      perr_pkt_q <= perr_pkt_n;
      perr_q     <= perr_n;
      vld_q      <= vld_n;
      sop_q      <= sop_n;
      last_q     <= last_n;
      err_q      <= err_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     data_q <= '0;
    else if (vld_n) data_q <= data_n;
  end

  assign idle      = ~busy_q;
  assign dn_valid  = vld_q;
  assign dn_sop    = sop_q;
  assign dn_last   = last_q;
  assign dn_err    = err_q;
  assign dn_data   = data_q;
  assign proto_err = perr_q;

  // R8
  gap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !pl_valid |=> proto_err && !dn_valid);
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
  // R7
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_last || dn_sop || dn_err) |-> dn_valid);
  // R9
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !busy_q);
endmodule

// File: rtl/txcg_arbiter.sv
module txcg_arbiter
  import txcg_pkg::*;
#(
  parameter int HC_W    = 8,
  parameter int DC_W    = 10,
  parameter int LEN_W   = 6,
  parameter int WORD_W  = 32,
  parameter int HC_INIT = 4,
  parameter int DC_INIT = 16,
  parameter int HC_LIM  = 8,
  parameter int DC_LIM  = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic [NUM_CLS*HC_W-1:0] avail_hdr,
  output logic [NUM_CLS*DC_W-1:0] avail_dat,
  input  logic                    req_valid,
  input  logic [1:0]              req_cls,
  input  logic [LEN_W-1:0]        req_len,
  output logic                    req_ack,
  input  logic                    pl_valid,
  input  logic [WORD_W-1:0]       pl_data,
  input  logic                    ret_valid,
  input  logic [1:0]              ret_cls,
  input  logic [HC_W-1:0]         ret_hdr,
  input  logic [DC_W-1:0]         ret_dat,
  output logic                    dn_valid,
  output logic                    dn_sop,
  output logic                    dn_last,
  output logic                    dn_err,
  output logic [WORD_W-1:0]       dn_data,
  output logic                    proto_err
);
  localparam int UP_W = LEN_W + 1;

  logic [1:0]         rst_sync_q;
  logic               srst_n;
  logic [UP_W-1:0]    len_up;
  logic [DC_W-1:0]    need_dat;
  logic [NUM_CLS-1:0] fits;
  logic [3:0]         fits_ext;
  logic               idle;
  logic               cls_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  assign len_up   = {1'b0, req_len} + UP_W'(3);
  assign need_dat = DC_W'(len_up >> 2);
  assign fits_ext = 4'(fits);
  assign cls_ok   = (tx_cls_e'(req_cls) != CLS_RSVD);
  assign req_ack  = req_valid & idle & cls_ok & fits_ext[req_cls];

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_pool
    txcg_credit_pool #(
      .HC_W(HC_W), .DC_W(DC_W), .HC_INIT(HC_INIT), .DC_INIT(DC_INIT),
      .HC_LIM(HC_LIM), .DC_LIM(DC_LIM)
    ) u_pool (
      .clk      (clk),
      .rst_n    (srst_n),
      .take     (req_ack && (req_cls == 2'(g))),
      .need_dat (need_dat),
      .give     (ret_valid && (ret_cls == 2'(g))),
      .give_hdr (ret_hdr),
      .give_dat (ret_dat),
      .hdr_cnt  (avail_hdr[g*HC_W +: HC_W]),
      .dat_cnt  (avail_dat[g*DC_W +: DC_W]),
      .fits     (fits[g])
    );
  end

  txcg_tx_seq #(.LEN_W(LEN_W), .WORD_W(WORD_W)) u_seq (
    .clk       (clk),
    .rst_n     (srst_n),
    .ack       (req_ack),
    .ack_cls   (req_cls),
    .ack_len   (req_len),
    .pl_valid  (pl_valid),
    .pl_data   (pl_data),
    .idle      (idle),
    .dn_valid  (dn_valid),
    .dn_sop    (dn_sop),
    .dn_last   (dn_last),
    .dn_err    (dn_err),
    .dn_data   (dn_data),
    .proto_err (proto_err)
  );

  // R2
  ack_class_chk: assert property (@(posedge clk) disable iff (!srst_n)
    req_ack |-> req_valid && (req_cls != 2'd3));
  // R3
  postpone_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    req_valid && !req_ack && !ret_valid |=> $stable(avail_hdr) && $stable(avail_dat));
  // R6
  ack_desc_chk: assert property (@(posedge clk) disable iff (!srst_n)
    req_ack |=> dn_valid && dn_sop);
endmodule

// File: tb/tb_txcg_arbiter.sv
`timescale 1ns/1ps
module tb_txcg_arbiter;
  localparam int HC_W = 4, DC_W = 5, LEN_W = 5, WORD_W = 32;
  localparam int HC_INIT = 2, DC_INIT = 4, HC_LIM = 3, DC_LIM = 6;

  logic clk, rst_n;
  logic [3*HC_W-1:0] avail_hdr;
  logic [3*DC_W-1:0] avail_dat;
  logic req_valid, req_ack, pl_valid, ret_valid;
  logic [1:0] req_cls, ret_cls;
  logic [LEN_W-1:0] req_len;
  logic [WORD_W-1:0] pl_data, dn_data;
  logic [HC_W-1:0] ret_hdr;
  logic [DC_W-1:0] ret_dat;
  logic dn_valid, dn_sop, dn_last, dn_err, proto_err;

  int checks = 0, errors = 0;
  int mh[3], md[3];

  txcg_arbiter #(.HC_W(HC_W), .DC_W(DC_W), .LEN_W(LEN_W), .WORD_W(WORD_W),
    .HC_INIT(HC_INIT), .DC_INIT(DC_INIT), .HC_LIM(HC_LIM), .DC_LIM(DC_LIM)) dut (
    .clk(clk), .rst_n(rst_n), .avail_hdr(avail_hdr), .avail_dat(avail_dat),
    .req_valid(req_valid), .req_cls(req_cls), .req_len(req_len), .req_ack(req_ack),
    .pl_valid(pl_valid), .pl_data(pl_data), .ret_valid(ret_valid), .ret_cls(ret_cls),
    .ret_hdr(ret_hdr), .ret_dat(ret_dat), .dn_valid(dn_valid), .dn_sop(dn_sop),
    .dn_last(dn_last), .dn_err(dn_err), .dn_data(dn_data), .proto_err(proto_err));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_avail(input string tag);
    for (int k = 0; k < 3; k++) begin
      check({tag, " hdr credits"}, avail_hdr[k*HC_W +: HC_W], mh[k]);
      check({tag, " data credits"}, avail_dat[k*DC_W +: DC_W], md[k]);
    end
  endtask

  function automatic int sat(input int v, input int lim);
    return (v > lim) ? lim : v;
  endfunction

  function automatic logic [31:0] pat(input int c, input int len, input int i);
    return 32'hA500_0000 | (c << 16) | (len << 8) | i;
  endfunction

  // checks descriptor beat (R6) then drives and checks payload (R7, R8)
  task automatic feed(input int c, input int len, input int gap_at);
    bit had_gap = (gap_at >= 0) && (gap_at < len);
    check("R6 desc valid", dn_valid, 1);
    check("R6 desc sop", dn_sop, 1);
    check("R6 desc last", dn_last, len == 0);
    check("R6 desc data", dn_data, (c << LEN_W) | len);
    for (int i = 0; i < len; i++) begin
      if (i == gap_at) begin
        pl_valid = 1'b0;
        @(negedge clk);
        check("R8 gap no beat", dn_valid, 0);
        check("R8 gap flag", proto_err, 1);
      end
      pl_valid = 1'b1;
      pl_data  = pat(c, len, i);
      @(negedge clk);
      check("R7 word valid", dn_valid, 1);
      check("R7 word sop", dn_sop, 0);
      check("R7 word data", dn_data, pat(c, len, i));
      check("R7 word last", dn_last, i == len - 1);
      check("R8 word err", dn_err, had_gap && (i == len - 1));
    end
    pl_valid = 1'b0;
  endtask

  task automatic send(input int c, input int len, input int gap_at, input int rh, input int rd);
    int need = (len + 3) / 4;
    bit exp_ack;
    @(negedge clk);
    req_valid = 1'b1; req_cls = 2'(c); req_len = LEN_W'(len);
    if (rh != 0 || rd != 0) begin
      ret_valid = 1'b1; ret_cls = 2'(c); ret_hdr = HC_W'(rh); ret_dat = DC_W'(rd);
    end
    #1;
    exp_ack = (c < 3) ? (mh[c % 3] >= 1 && md[c % 3] >= need) : 1'b0;
    check("R2 ack decision", req_ack, exp_ack);
    @(negedge clk);
    req_valid = 1'b0; ret_valid = 1'b0;
    if (c < 3) begin
      if (exp_ack) begin
        mh[c] = sat(mh[c] - 1 + rh, HC_LIM);
        md[c] = sat(md[c] - need + rd, DC_LIM);
      end else begin
        mh[c] = sat(mh[c] + rh, HC_LIM);
        md[c] = sat(md[c] + rd, DC_LIM);
      end
    end
    if (!exp_ack) begin
      check("R3 postponed no beat", dn_valid, 0);
      check_avail("R3 postponed");
    end else begin
      check_avail((rh != 0 || rd != 0) ? "R5 combined" : "R4 consume");
      feed(c, len, gap_at);
    end
  endtask

  task automatic ret(input int c, input int h, input int d);
    @(negedge clk);
    ret_valid = 1'b1; ret_cls = 2'(c); ret_hdr = HC_W'(h); ret_dat = DC_W'(d);
    @(negedge clk);
    ret_valid = 1'b0;
    if (c < 3) begin
      mh[c] = sat(mh[c] + h, HC_LIM);
      md[c] = sat(md[c] + d, DC_LIM);
    end
    check_avail("R5 return");
  endtask

  task automatic topup();
    for (int k = 0; k < 3; k++) ret(k, (1 << HC_W) - 1, (1 << DC_W) - 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 0; req_cls = 0; req_len = 0; pl_valid = 0; pl_data = 0;
    ret_valid = 0; ret_cls = 0; ret_hdr = 0; ret_dat = 0;
    for (int k = 0; k < 3; k++) begin mh[k] = HC_INIT; md[k] = DC_INIT; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check_avail("R1 reset");
    check("R1 no ack", req_ack, 0);
    check("R1 no beat", dn_valid, 0);
    check("R1 no error", proto_err, 0);

    // R9 payload ignored while idle
    pl_valid = 1'b1; pl_data = 32'hDEAD;
    @(negedge clk);
    pl_valid = 1'b0;
    check("R9 idle payload ignored", dn_valid, 0);
    check_avail("R9 idle");

    // sweep class x length from full credits
    for (int c = 0; c < 4; c++)
      for (int len = 0; len <= 24; len++) begin
        topup();
        send(c, len, -1, 0, 0);
      end

    // exhaustion of header credits
    topup();
    for (int n = 0; n < 4; n++) send(1, 8, -1, 0, 0);

    // R3 postponed request held, then granted after a return
    topup();
    send(2, 24, -1, 0, 0);
    @(negedge clk);
    req_valid = 1'b1; req_cls = 2'd2; req_len = LEN_W'(4);
    for (int n = 0; n < 3; n++) begin
      #1; check("R3 held postponed", req_ack, 0);
      @(negedge clk);
      check_avail("R3 held");
    end
    ret_valid = 1'b1; ret_cls = 2'd2; ret_hdr = '0; ret_dat = DC_W'(1);
    #1; check("R3 before return edge", req_ack, 0);
    @(negedge clk);
    ret_valid = 1'b0; md[2] = md[2] + 1;
    #1; check("R3 recheck grants", req_ack, 1);
    @(negedge clk);
    req_valid = 1'b0; mh[2] = mh[2] - 1; md[2] = md[2] - 1;
    check_avail("R4 after held grant");
    feed(2, 4, -1);

    // R9 no second grant during payload
    topup();
    @(negedge clk);
    req_valid = 1'b1; req_cls = 2'd0; req_len = LEN_W'(3);
    #1; check("R2 first grant", req_ack, 1);
    @(negedge clk);
    mh[0] = mh[0] - 1; md[0] = md[0] - 1;
    req_cls = 2'd1; req_len = '0;
    #1; check("R9 busy blocks ack", req_ack, 0);
    req_valid = 1'b0;
    feed(0, 3, -1);
    check_avail("R9 busy");

    // R5 consume and return in the same cycle
    topup();
    send(1, 4, -1, 0, 0);
    send(1, 8, -1, 1, 3);

    // R8 gaps
    topup();
    send(0, 5, 2, 0, 0);
    send(0, 3, -1, 0, 0);
    check("R8 sticky flag", proto_err, 1);
    send(1, 4, 0, 0, 0);
    send(2, 1, 0, 0, 0);
    check("R8 sticky end", proto_err, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule